// File: doc/BRIEF.md
# SPI Serial Clock and Select-Lead Timer

This block turns the system clock into the serial clock of an SPI master and times the whole frame around it. A one-cycle start request drops the active-low chip-select. The block then waits a programmable lead time and toggles the serial clock for a fixed number of edges. Half a clock period after the last edge it raises chip-select again. Neighbouring logic uses the per-edge strobes to shift data in and out. Those strobes are high in exactly the cycle where the serial clock shows its new level.

Two encoded pairs of fields set the timing. The first pair is a prescaler code and a scaler code. Together with a rate-doubling bit, they set the serial clock period. The second pair is also a prescaler code and a scaler code, and it sets the lead time from chip-select to the first clock edge. All fields are captured when the start request is accepted and are held for the whole frame. The inputs may therefore change freely while a frame runs.

Top module: `spiClkGen`

## Requirements
- R1: While reset is high, and at the first edge after it, csN is 1, sck is 0, and sckRise and sckFall are 0.
- R2: A start high at a clock edge while the block is idle (csN high) makes csN read 0 after that edge.
- R3: The first sck rise comes D system cycles after the first cycle with csN low. D is the lead prescaler value times the lead scaler value. Lead prescaler codes 0,1,2,3 give 2,3,5,7. Lead scaler code n gives 2^(n+1), for example code 1 with code 4 gives 96.
- R4: The sck period is P = prescaler × scaler / (1 + rateDouble) system cycles. The baud prescaler codes use the same 2,3,5,7 table as the lead prescaler. Baud scaler codes 0..3 give 2,4,6,8, and codes n ≥ 4 give 2^n.
- R5: When P is odd, the high phase lasts (P+1)/2 cycles and the low phase lasts (P−1)/2 cycles, so the period stays exact.
- R6: Each frame has exactly 16 sck edges. The first edge rises and the last edge falls. While csN is high, sck is low.
- R7: csN returns to 1 exactly one low-phase length (P/2 rounded down) after the last falling edge.
- R8: A start while csN is low has no effect on the frame's edges or its end.
- R9: Configuration inputs that change after the start edge do not alter the running frame.
- R10: sckRise and sckFall are each high for one cycle, exactly in the cycles where sck has just risen or fallen, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame request, sampled on the clock edge |
| baudPreSel | input | 2 | Baud prescaler code |
| baudScaleSel | input | 4 | Baud scaler code |
| rateDouble | input | 1 | Halves the sck period when set |
| leadPreSel | input | 2 | Lead-time prescaler code |
| leadScaleSel | input | 4 | Lead-time scaler code |
| csN | output | 1 | Chip-select, active low |
| sck | output | 1 | Serial clock, idle low |
| sckRise | output | 1 | High in the cycle sck has just risen |
| sckFall | output | 1 | High in the cycle sck has just fallen |

## Verification
The bench targets the odd doubled period (prescaler 3, scaler 2, doubling on). A design that splits this period evenly would drift by one cycle per edge, or would emit a zero-length phase. The minimum doubled period of two cycles is also exercised, where an off-by-one in the countdown would stretch or freeze the clock. Lead times of 4, 10, 56 and 96 cycles show whether the lead count is off by one cycle or reads the wrong lookup entry. A start pulse during a frame and configuration changes after the start edge check that a design does not restart the frame or pick up new timing mid-frame.

// File: rtl/spiClkPkg.sv
package spiClkPkg;

  typedef struct packed {
    logic cfgLoad;
    logic ldLead;
    logic ldHigh;
    logic ldLow;
    logic sckSet;
    logic sckClr;
  } dpCtlT;

  function automatic logic [2:0] preValue(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd2;
      2'd1:    return 3'd3;
      2'd2:    return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  function automatic logic [15:0] baudScale(input logic [3:0] code);
    if (code < 4'd4) return {11'd0, code, 1'b0} + 16'd2;
    return 16'd1 << code;
  endfunction

endpackage

// File: rtl/spiClkDatapath.sv
module spiClkDatapath
  import spiClkPkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  dpCtlT      ctl,
  input  logic [1:0] baudPreSel,
  input  logic [3:0] baudScaleSel,
  input  logic       rateDouble,
  input  logic [1:0] leadPreSel,
  input  logic [3:0] leadScaleSel,
  output logic       sck,
  output logic       sckRise,
  output logic       sckFall,
  output logic       cntZero
);

  logic [1:0] bpReg, lpReg;
  logic [3:0] bsReg, lsReg;
  logic       dblReg;
  logic [1:0] bpSel, lpSel;
  logic [3:0] bsSel, lsSel;
  logic       dblSel;
  logic [CNT_W-1:0] leadLen, fullPer, period, highLen, lowLen, cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bpReg <= '0; bsReg <= '0; dblReg <= 1'b0; lpReg <= '0; lsReg <= '0;
    end else if (ctl.cfgLoad) begin
      bpReg <= baudPreSel; bsReg <= baudScaleSel; dblReg <= rateDouble;
      lpReg <= leadPreSel; lsReg <= leadScaleSel;
    end
  end

  always_comb begin
    bpSel  = ctl.cfgLoad ? baudPreSel   : bpReg;
    bsSel  = ctl.cfgLoad ? baudScaleSel : bsReg;
    dblSel = ctl.cfgLoad ? rateDouble   : dblReg;
    lpSel  = ctl.cfgLoad ? leadPreSel   : lpReg;
    lsSel  = ctl.cfgLoad ? leadScaleSel : lsReg;
    leadLen = CNT_W'(preValue(lpSel)) << ({1'b0, lsSel} + 5'd1);
    fullPer = CNT_W'(preValue(bpSel)) * CNT_W'(baudScale(bsSel));
    period  = dblSel ? (fullPer >> 1) : fullPer;
    lowLen  = period >> 1;
    highLen = period - lowLen;
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ctl.ldLead)  cnt <= leadLen - CNT_W'(1);
    else if (ctl.ldHigh)  cnt <= highLen - CNT_W'(1);
    else if (ctl.ldLow)   cnt <= lowLen - CNT_W'(1);
    else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck <= 1'b0; sckRise <= 1'b0; sckFall <= 1'b0;
    end else begin
      if (ctl.sckSet)      sck <= 1'b1;
      else if (ctl.sckClr) sck <= 1'b0;
      sckRise <= ctl.sckSet;
      sckFall <= ctl.sckClr;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sckRise && sckFall)); // R10
  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (rst)
    sckRise |-> (sck && !$past(sck))); // R10
  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (rst)
    sckFall |-> (!sck && $past(sck))); // R10

endmodule

// File: rtl/spiClkControl.sv
module spiClkControl
  import spiClkPkg::*;
#(
  parameter int EDGES = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  cntZero,
  input  logic  sck,
  output dpCtlT ctl,
  output logic  csN
);

  localparam int EW = $clog2(EDGES + 1);

  typedef enum logic [1:0] {IDLE, LEAD, RUN, TRAIL} stateT;
  stateT state, nxt;
  logic [EW-1:0] edgeCnt;

  always_comb begin
    ctl = '0;
    nxt = state;
    case (state)
      IDLE: if (start) begin
        ctl.cfgLoad = 1'b1; ctl.ldLead = 1'b1; nxt = LEAD;
      end
      LEAD: if (cntZero) begin
        ctl.sckSet = 1'b1; ctl.ldHigh = 1'b1; nxt = RUN;
      end
      RUN: if (cntZero) begin
        if (sck) begin
          ctl.sckClr = 1'b1; ctl.ldLow = 1'b1;
          if (edgeCnt == EW'(EDGES - 1)) nxt = TRAIL;
        end else begin
          ctl.sckSet = 1'b1; ctl.ldHigh = 1'b1;
        end
      end
      default: if (cntZero) nxt = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= IDLE; edgeCnt <= '0; csN <= 1'b1;
    end else begin
      state <= nxt;
      csN   <= (nxt == IDLE);
      if (ctl.cfgLoad)                  edgeCnt <= '0;
      else if (ctl.sckSet || ctl.sckClr) edgeCnt <= edgeCnt + EW'(1);
    end
  end

  AST_CS_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> $past(start)); // R2
  AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    edgeCnt <= EW'(EDGES)); // R6

endmodule

// File: rtl/spiClkGen.sv
module spiClkGen
  import spiClkPkg::*;
#(
  parameter int EDGES = 16,
  parameter int CNT_W = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] baudPreSel,
  input  logic [3:0] baudScaleSel,
  input  logic       rateDouble,
  input  logic [1:0] leadPreSel,
  input  logic [3:0] leadScaleSel,
  output logic       csN,
  output logic       sck,
  output logic       sckRise,
  output logic       sckFall
);

  dpCtlT ctl;
  logic  cntZero;

  spiClkControl #(.EDGES(EDGES)) uCtl (
    .clk(clk), .rst(rst), .start(start), .cntZero(cntZero), .sck(sck),
    .ctl(ctl), .csN(csN)
  );

  spiClkDatapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl),
    .baudPreSel(baudPreSel), .baudScaleSel(baudScaleSel), .rateDouble(rateDouble),
    .leadPreSel(leadPreSel), .leadScaleSel(leadScaleSel),
    .sck(sck), .sckRise(sckRise), .sckFall(sckFall), .cntZero(cntZero)
  );

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    csN |-> !sck); // R6

endmodule

// File: tb/tb_spiClkGen.sv
module tb_spiClkGen;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] baudPreSel = '0, leadPreSel = '0;
  logic [3:0] baudScaleSel = '0, leadScaleSel = '0;
  logic rateDouble = 1'b0;
  logic csN, sck, sckRise, sckFall;

  spiClkGen dut (
    .clk(clk), .rst(rst), .start(start),
    .baudPreSel(baudPreSel), .baudScaleSel(baudScaleSel), .rateDouble(rateDouble),
    .leadPreSel(leadPreSel), .leadScaleSel(leadScaleSel),
    .csN(csN), .sck(sck), .sckRise(sckRise), .sckFall(sckFall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum int {EV_CSLOW, EV_RISE, EV_FALL, EV_CSHIGH} evT;
  typedef struct { evT kind; longint cyc; string req; } itemT;
  itemT expQ[$];

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit monOn = 1'b0, done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int preV(input logic [1:0] c);
    case (c) 2'd0: return 2; 2'd1: return 3; 2'd2: return 5; default: return 7; endcase
  endfunction

  function automatic int bScaV(input logic [3:0] c);
    if (c < 4) return 2 * (int'(c) + 1);
    return 1 << c;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: detect events at negedge, pop and compare
  logic prevCs = 1'b1, prevSck = 1'b0;
  always @(negedge clk) begin
    if (monOn) begin
      if ((sckRise !== (sck && !prevSck)) || (sckFall !== (!sck && prevSck))) begin
        checks++; errors++;
        $display("FAIL R10 strobes rise=%0b fall=%0b expected rise=%0b fall=%0b",
                 sckRise, sckFall, sck && !prevSck, !sck && prevSck);
      end else if (sckRise || sckFall) checks++;
      if (csN !== prevCs) popCheck(csN ? EV_CSHIGH : EV_CSLOW);
      if (sck !== prevSck) popCheck(sck ? EV_RISE : EV_FALL);
    end
    prevCs = csN; prevSck = sck;
  end

  task automatic popCheck(input evT k);
    itemT it;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R6/R8 unexpected event actual=%0d@%0d expected none", k, cyc);
      return;
    end
    it = expQ.pop_front();
    if (it.kind != k || it.cyc != cyc) begin
      errors++;
      $display("FAIL %s event actual=%0d@%0d expected=%0d@%0d", it.req, k, cyc, it.kind, it.cyc);
    end
  endtask

  // driver: mode 0 plain, 1 extra start mid-frame (R8), 2 config change (R9)
  task automatic doXfer(input logic [1:0] bp, input logic [3:0] bs, input logic dbl,
                        input logic [1:0] lp, input logic [3:0] ls, input int mode);
    longint t0, t, tEnd;
    int per, hi, lo, lead;
    string tag;
    itemT it;
    per  = preV(bp) * bScaV(bs) / (dbl ? 2 : 1);
    lo   = per / 2;
    hi   = per - lo;
    lead = preV(lp) * (1 << (int'(ls) + 1));
    tag  = (mode == 1) ? "R8" : (mode == 2) ? "R9" : "";
    @(negedge clk);
    baudPreSel = bp; baudScaleSel = bs; rateDouble = dbl;
    leadPreSel = lp; leadScaleSel = ls; start = 1'b1;
    t0 = cyc + 1;
    it.kind = EV_CSLOW; it.cyc = t0; it.req = (tag != "") ? tag : "R2"; expQ.push_back(it);
    t = t0 + lead;
    it.kind = EV_RISE; it.cyc = t; it.req = (tag != "") ? tag : "R3"; expQ.push_back(it);
    for (int k = 1; k < 16; k++) begin
      t += (k % 2 == 1) ? hi : lo;
      it.kind = (k % 2 == 1) ? EV_FALL : EV_RISE;
      it.cyc = t;
      it.req = (tag != "") ? tag : (hi != lo) ? "R5" : "R4";
      expQ.push_back(it);
    end
    tEnd = t + lo;
    it.kind = EV_CSHIGH; it.cyc = tEnd; it.req = (tag != "") ? tag : "R7"; expQ.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (mode == 2) begin
      baudPreSel = 2'd0; baudScaleSel = 4'd0; rateDouble = 1'b1;
      leadPreSel = 2'd0; leadScaleSel = 4'd0;
    end
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (cyc < t0 + lead + 2 * per) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (cyc < tEnd + 2) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R6 missing events actual=%0d left expected=0", expQ.size());
      expQ.delete();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (csN !== 1'b1 || sck !== 1'b0 || sckRise !== 1'b0 || sckFall !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual=%b%b%b%b expected=1000", csN, sck, sckRise, sckFall);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (csN !== 1'b1 || sck !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset actual=%b%b expected=10", csN, sck);
    end
    prevCs = csN; prevSck = sck;
    monOn = 1'b1;
    doXfer(2'd0, 4'd0, 1'b0, 2'd0, 4'd0, 0); // R4 P=4, R3 lead 4
    doXfer(2'd0, 4'd0, 1'b1, 2'd0, 4'd0, 0); // R4 doubled P=2
    doXfer(2'd1, 4'd0, 1'b1, 2'd1, 4'd4, 0); // R5 P=3, R3 lead 96
    doXfer(2'd3, 4'd5, 1'b0, 2'd3, 4'd2, 0); // R4 P=224, R3 lead 56
    doXfer(2'd1, 4'd4, 1'b1, 2'd2, 4'd0, 0); // R4 scaler 16, P=24
    doXfer(2'd2, 4'd3, 1'b1, 2'd2, 4'd0, 1); // R8 start while busy
    doXfer(2'd2, 4'd3, 1'b1, 2'd2, 4'd0, 2); // R9 config change mid-frame
    repeat (5) @(negedge clk);
    report();
  end

endmodule